// File: doc/BRIEF.md
# Timestamp LRU Victim Selector

This block picks the way of a cache set to evict on a miss. Each way of the set carries a valid bit and a stored logical timestamp; the cache presents both for the addressed set, and the block answers in the same cycle with the way to replace and a flag showing whether that way was empty. An empty way is always taken first, the lowest-numbered one when there are several. When the set is full, the way with the oldest timestamp is taken. Equal timestamps go to the lowest-numbered way.

The block owns the global reference counter. The counter starts at zero, rises by one in every cycle that carries an access, and stops at its maximum value instead of wrapping around. On a hit or a fill the block produces a timestamp write-back for the surrounding cache to store: a write strobe, the target way and the value. That value is the count that includes the current access. Tag and data storage, tag comparison and the store of the timestamps themselves belong to the surrounding cache. Every pin is a plain level-sensitive control or status signal and none has a handshake, so there are no back-pressure rules. The access pulses act on the clock edge, and the selection outputs are combinational.

Top module: `lru_victim_sel`

## Requirements
- R1: After reset the reference count output is 0. Each clock edge with `acc_i` high adds one to the count. An edge with `acc_i` low leaves it unchanged.
- R2: The count stops at 2^TSW-1 and stays there on further accesses. While the count is at that value, the write-back value is also 2^TSW-1.
- R3: When `hit_i` is high, in the same cycle `stamp_we_o` is 1, `stamp_way_o` equals `hit_way_i`, and `stamp_val_o` is the count plus one if `acc_i` is high (capped at 2^TSW-1), or the count itself if `acc_i` is low.
- R4: When `fill_i` is high and `hit_i` is low, the write-back targets `fill_way_i` with the value defined in R3. When both are high, the hit way wins. When neither is high, `stamp_we_o` is 0.
- R5: If any bit of `set_valid_i` is 0 (bit i is way i), `victim_o` is the lowest-numbered invalid way and `victim_empty_o` is 1. Timestamps play no part in this choice.
- R6: If every way is valid, `victim_o` is the way whose timestamp is smallest, unsigned, and `victim_empty_o` is 0. Way i's timestamp sits in `set_stamp_i[i*TSW +: TSW]`.
- R7: When several valid ways share the smallest timestamp, the lowest-numbered of them is chosen.
- R8: With WAYS=1, `victim_o` is always 0 and `victim_empty_o` is the inverse of the single valid bit.
- R9: Victim and flag are combinational: they follow `set_valid_i` and `set_stamp_i` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_i | input | 1 | An access occurs this cycle |
| hit_i | input | 1 | The access hit |
| hit_way_i | input | WIDX | Way that hit |
| fill_i | input | 1 | A way is being filled |
| fill_way_i | input | WIDX | Way being filled |
| set_valid_i | input | WAYS | Valid bits of the addressed set |
| set_stamp_i | input | WAYS*TSW | Timestamps of the addressed set, way 0 in the low bits |
| victim_o | output | WIDX | Way chosen for replacement |
| victim_empty_o | output | 1 | Chosen way is invalid |
| stamp_we_o | output | 1 | Timestamp write-back strobe |
| stamp_way_o | output | WIDX | Way to receive the timestamp |
| stamp_val_o | output | TSW | Timestamp value to store |
| refcnt_o | output | TSW | Current reference count |

## Verification
The count is the only state in the block. A count that skips, stalls or wraps shows up on `refcnt_o` one edge after the access that caused it. It also shows up in the same cycle on `stamp_val_o` of the next hit or fill, and the saturation test drives the count past its top to catch a wrap. A fault in the selection logic carries no history. It shows immediately on `victim_o` or `victim_empty_o` for the set pattern being presented, so the patterns cover empty ways placed above full ones, a single oldest way in each position, and ties.

// File: rtl/lru_pkg.sv
package lru_pkg;
  // Source of a timestamp write-back
  typedef enum logic [1:0] {
    STAMP_NONE = 2'd0,
    STAMP_HIT  = 2'd1,
    STAMP_FILL = 2'd2
  } stamp_src_e;
endpackage

// File: rtl/lru_refcnt.sv
module lru_refcnt #(
  parameter int TSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_i,
  output logic [TSW-1:0] cnt_o,
  output logic [TSW-1:0] cnt_next_o
);
  localparam logic [TSW-1:0] CNT_MAX = {TSW{1'b1}};

  logic [TSW-1:0] cnt_q;

  // Count including the access of this cycle, held at the top value
  always_comb begin
    if (acc_i && (cnt_q != CNT_MAX)) cnt_next_o = cnt_q + 1'b1;
    else                             cnt_next_o = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lru_pick.sv
module lru_pick #(
  parameter int WAYS = 4,
  parameter int TSW  = 16,
  localparam int WIDX = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]     valid_i,
  input  logic [WAYS*TSW-1:0] stamp_i,
  output logic [WIDX-1:0]     way_o,
  output logic                empty_o
);
  generate
    if (WAYS == 1) begin : g_direct
      assign way_o   = '0;
      assign empty_o = ~valid_i[0];
    end else begin : g_assoc
      logic [TSW-1:0]  best;
      logic [WIDX-1:0] pick;
      logic            hole;

      always_comb begin
        hole = 1'b0;
        pick = '0;
        best = stamp_i[TSW-1:0];
        // empty ways first, lowest index
        for (int i = 0; i < WAYS; i++) begin
          if (!hole && !valid_i[i]) begin
            hole = 1'b1;
            pick = WIDX'(i);
          end
        end
        // full set: strict less-than keeps the lowest index on ties
        if (!hole) begin
          for (int i = 1; i < WAYS; i++) begin
            if (stamp_i[i*TSW +: TSW] < best) begin
              best = stamp_i[i*TSW +: TSW];
              pick = WIDX'(i);
            end
          end
        end
      end

      assign way_o   = pick;
      assign empty_o = hole;
    end
  endgenerate
endmodule

// File: rtl/lru_stamp_wr.sv
module lru_stamp_wr #(
  parameter int WAYS = 4,
  parameter int TSW  = 16,
  localparam int WIDX = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            hit_i,
  input  logic [WIDX-1:0] hit_way_i,
  input  logic            fill_i,
  input  logic [WIDX-1:0] fill_way_i,
  input  logic [TSW-1:0]  cnt_next_i,
  output logic            we_o,
  output logic [WIDX-1:0] way_o,
  output logic [TSW-1:0]  val_o
);
  import lru_pkg::*;

  stamp_src_e src;

  always_comb begin
    if (hit_i)       src = STAMP_HIT;
    else if (fill_i) src = STAMP_FILL;
    else             src = STAMP_NONE;
  end

  always_comb begin
    unique case (src)
      STAMP_HIT:  way_o = hit_way_i;
      STAMP_FILL: way_o = fill_way_i;
      default:    way_o = '0;
    endcase
  end

  assign we_o  = (src != STAMP_NONE);
  assign val_o = cnt_next_i;
endmodule

// File: rtl/lru_victim_sel.sv
module lru_victim_sel #(
  parameter int WAYS = 4,
  parameter int TSW  = 16,
  localparam int WIDX = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_i,
  input  logic                hit_i,
  input  logic [WIDX-1:0]     hit_way_i,
  input  logic                fill_i,
  input  logic [WIDX-1:0]     fill_way_i,
  input  logic [WAYS-1:0]     set_valid_i,
  input  logic [WAYS*TSW-1:0] set_stamp_i,
  output logic [WIDX-1:0]     victim_o,
  output logic                victim_empty_o,
  output logic                stamp_we_o,
  output logic [WIDX-1:0]     stamp_way_o,
  output logic [TSW-1:0]      stamp_val_o,
  output logic [TSW-1:0]      refcnt_o
);
  logic [TSW-1:0] cnt_next;

  lru_refcnt #(.TSW(TSW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_i      (acc_i),
    .cnt_o      (refcnt_o),
    .cnt_next_o (cnt_next)
  );

  lru_pick #(.WAYS(WAYS), .TSW(TSW)) u_pick (
    .valid_i (set_valid_i),
    .stamp_i (set_stamp_i),
    .way_o   (victim_o),
    .empty_o (victim_empty_o)
  );

  lru_stamp_wr #(.WAYS(WAYS), .TSW(TSW)) u_wr (
    .hit_i      (hit_i),
    .hit_way_i  (hit_way_i),
    .fill_i     (fill_i),
    .fill_way_i (fill_way_i),
    .cnt_next_i (cnt_next),
    .we_o       (stamp_we_o),
    .way_o      (stamp_way_o),
    .val_o      (stamp_val_o)
  );
endmodule

// File: rtl/lru_victim_sel_chk.sv
module lru_victim_sel_chk #(
  parameter int WAYS = 4,
  parameter int TSW  = 16,
  localparam int WIDX = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acc_i,
  input logic                hit_i,
  input logic                fill_i,
  input logic [WAYS-1:0]     set_valid_i,
  input logic [WAYS*TSW-1:0] set_stamp_i,
  input logic [WIDX-1:0]     victim_o,
  input logic                victim_empty_o,
  input logic                stamp_we_o,
  input logic [TSW-1:0]      stamp_val_o,
  input logic [TSW-1:0]      refcnt_o
);
  localparam logic [TSW-1:0] CNT_MAX = {TSW{1'b1}};

  logic [TSW-1:0] vstamp;
  logic           older_seen;
  logic           tie_below;

  always_comb begin
    vstamp     = '0;
    older_seen = 1'b0;
    tie_below  = 1'b0;
    for (int i = 0; i < WAYS; i++)
      if (WIDX'(i) == victim_o) vstamp = set_stamp_i[i*TSW +: TSW];
    for (int i = 0; i < WAYS; i++) begin
      if (set_stamp_i[i*TSW +: TSW] < vstamp) older_seen = 1'b1;
      if ((set_stamp_i[i*TSW +: TSW] == vstamp) && (WIDX'(i) < victim_o)) tie_below = 1'b1;
    end
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && refcnt_o != CNT_MAX) |=> refcnt_o == $past(refcnt_o) + 1'b1);
  p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_i |=> $stable(refcnt_o));
  p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (refcnt_o == CNT_MAX) |=> refcnt_o == CNT_MAX);
  p_fresh_stamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stamp_we_o && acc_i && refcnt_o != CNT_MAX) |-> stamp_val_o > refcnt_o);
  p_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_we_o |-> (hit_i || fill_i));
  p_empty_way_r5: assert property (@(posedge clk) disable iff (!rst_n)
    victim_empty_o |-> !set_valid_i[victim_o]);
  p_full_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_empty_o |-> (&set_valid_i && !older_seen));
  p_tie_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_empty_o |-> !tie_below);
  p_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(victim_o) < WAYS);
endmodule

bind lru_victim_sel lru_victim_sel_chk #(.WAYS(WAYS), .TSW(TSW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_i          (acc_i),
  .hit_i          (hit_i),
  .fill_i         (fill_i),
  .set_valid_i    (set_valid_i),
  .set_stamp_i    (set_stamp_i),
  .victim_o       (victim_o),
  .victim_empty_o (victim_empty_o),
  .stamp_we_o     (stamp_we_o),
  .stamp_val_o    (stamp_val_o),
  .refcnt_o       (refcnt_o)
);

// File: tb/tb_lru_victim_sel.sv
module tb_lru_victim_sel;
  localparam int WAYS = 4;
  localparam int TSW  = 4;
  localparam int WIDX = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            acc, hit, fill;
  logic [WIDX-1:0] hit_way, fill_way;
  logic [WAYS-1:0] vld;
  logic [WAYS*TSW-1:0] stm;
  logic [WIDX-1:0] victim, swy;
  logic            empty, we;
  logic [TSW-1:0]  sval, cnt;

  logic            vld1;
  logic [0:0]      victim1, swy1;
  logic            empty1, we1;
  logic [TSW-1:0]  sval1, cnt1;

  int total = 0;
  int bad = 0;
  int mcnt = 0;

  lru_victim_sel #(.WAYS(WAYS), .TSW(TSW)) dut (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .hit_i(hit), .hit_way_i(hit_way),
    .fill_i(fill), .fill_way_i(fill_way), .set_valid_i(vld), .set_stamp_i(stm),
    .victim_o(victim), .victim_empty_o(empty), .stamp_we_o(we),
    .stamp_way_o(swy), .stamp_val_o(sval), .refcnt_o(cnt));

  lru_victim_sel #(.WAYS(1), .TSW(TSW)) dut_dm (
    .clk(clk), .rst_n(rst_n), .acc_i(1'b0), .hit_i(1'b0), .hit_way_i(1'b0),
    .fill_i(1'b0), .fill_way_i(1'b0), .set_valid_i(vld1), .set_stamp_i(4'h5),
    .victim_o(victim1), .victim_empty_o(empty1), .stamp_we_o(we1),
    .stamp_way_o(swy1), .stamp_val_o(sval1), .refcnt_o(cnt1));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [WAYS*TSW-1:0] pack(input int s3, input int s2, input int s1, input int s0);
    return {TSW'(s3), TSW'(s2), TSW'(s1), TSW'(s0)};
  endfunction

  function automatic int nextc();
    return (mcnt == 15) ? 15 : mcnt + 1;
  endfunction

  task automatic idle();
    @(negedge clk);
    acc = 0; hit = 0; fill = 0; hit_way = 0; fill_way = 0;
  endtask

  task automatic pulse();
    @(negedge clk); acc = 1;
    @(negedge clk); acc = 0;
    mcnt = nextc();
  endtask

  task automatic t_reset();
    check("R1 reset count", cnt, 0);
    check("R4 idle strobe", we, 0);
  endtask

  task automatic t_count();
    pulse(); pulse(); pulse();
    check("R1 three accesses", cnt, 3);
    idle(); idle();
    check("R1 hold when idle", cnt, 3);
  endtask

  task automatic t_hit();
    @(negedge clk); acc = 1; hit = 1; hit_way = 2; #1;
    check("R3 hit strobe", we, 1);
    check("R3 hit way", swy, 2);
    check("R3 hit value", sval, nextc());
    @(negedge clk); acc = 0; hit = 0; mcnt = nextc();
    #1 check("R1 count after hit", cnt, mcnt);
    hit = 1; hit_way = 1; #1;
    check("R3 hit no access value", sval, mcnt);
    hit = 0;
  endtask

  task automatic t_fill();
    @(negedge clk); acc = 1; fill = 1; fill_way = 3; #1;
    check("R4 fill strobe", we, 1);
    check("R4 fill way", swy, 3);
    check("R4 fill value", sval, nextc());
    hit = 1; hit_way = 1; #1;
    check("R4 hit beats fill", swy, 1);
    @(negedge clk); acc = 0; hit = 0; fill = 0; mcnt = nextc(); #1;
    check("R4 no strobe", we, 0);
  endtask

  task automatic t_empty();
    vld = 4'b1011; stm = pack(0, 0, 0, 0); #1;
    check("R5 empty way2", victim, 2);
    check("R5 empty flag", empty, 1);
    vld = 4'b0110; stm = pack(1, 9, 9, 15); #1;
    check("R5 lowest empty", victim, 0);
    vld = 4'b0111; stm = pack(15, 0, 0, 0); #1;
    check("R5 empty over old", victim, 3);
    check("R5 empty flag high way", empty, 1);
  endtask

  task automatic t_oldest();
    vld = 4'b1111; stm = pack(9, 3, 7, 5); #1;
    check("R6 oldest way2", victim, 2);
    check("R6 flag low", empty, 0);
    stm = pack(1, 8, 8, 8); #1;
    check("R6 oldest way3", victim, 3);
    stm = pack(14, 15, 13, 0); #1;
    check("R9 same cycle way0", victim, 0);
  endtask

  task automatic t_tie();
    vld = 4'b1111; stm = pack(2, 6, 2, 9); #1;
    check("R7 tie low", victim, 1);
    stm = pack(4, 4, 4, 4); #1;
    check("R7 all equal", victim, 0);
  endtask

  task automatic t_direct();
    vld1 = 1'b1; #1;
    check("R8 dm victim valid", victim1, 0);
    check("R8 dm flag valid", empty1, 0);
    vld1 = 1'b0; #1;
    check("R8 dm victim empty", victim1, 0);
    check("R8 dm flag empty", empty1, 1);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 20; k++) pulse();
    check("R2 saturated count", cnt, 15);
    @(negedge clk); acc = 1; hit = 1; hit_way = 0; #1;
    check("R2 value at max", sval, 15);
    @(negedge clk); acc = 0; hit = 0; #1;
    check("R2 no wrap", cnt, 15);
  endtask

  initial begin
    acc = 0; hit = 0; fill = 0; hit_way = 0; fill_way = 0;
    vld = '0; stm = '0; vld1 = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_count();
    t_hit();
    t_fill();
    t_empty();
    t_oldest();
    t_tie();
    t_direct();
    t_saturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule